// File: doc/BRIEF.md
# Receive Character Buffer with Overrun Latch

This unit sits behind a serial deserializer. Each completed character arrives as a one-cycle strobe with an 8-bit value. While reception is enabled and no overrun is pending, the character goes into a 16-entry first-in first-out buffer. The CPU reaches the unit over a small register bus with two addresses. Reading the data address returns the oldest character and removes it from the buffer. The status address holds one live bit, the overrun flag, which sits in bit 0 of a 16-bit word.

When a character completes while every buffer slot is occupied, the unit keeps the stored characters, drops the new one and raises the overrun flag. While the flag is up, reception is stalled: incoming characters are dropped even if the CPU has freed slots. To release the stall, software reads the status word and sees the flag at 1, which arms a hidden latch. A later write of 0 to bit 0 then clears the flag and also consumes the latch.

The receive-enable input gates the intake of new characters only. Lowering it leaves the flag and the buffer contents as they are.

Top module: `rxbuf_unit`

## Requirements
- R1: After a synchronous active-low reset, `fill_count` is 0, `rx_blocked` is 0 and a status read returns 16'h0000.
- R2: A `char_valid` strobe with `rx_en`=1, no flag set and room in the buffer stores `char_data`, and `fill_count` rises by one on the next clock edge. The buffer holds 16 characters.
- R3: A read with `reg_addr`=0 returns the oldest stored character in bits 7:0, with bits 15:8 at 0, in the cycle the read is presented, and removes that character. A data read of an empty buffer returns 0 and leaves `fill_count` at 0.
- R4: A read with `reg_addr`=1 returns the overrun flag in bit 0 and 0 in bits 15:1. Writing 1s to bits 15:1 has no effect.
- R5: A character that completes while 16 characters are held, with no data read in the same cycle, sets the overrun flag. That character is discarded and the 16 stored characters stay intact and in order.
- R6: A character that completes while the buffer is full, in the same cycle as a data read, is stored and does not set the flag.
- R7: While the flag is 1, `rx_blocked` is 1 and no character is stored, even after data reads free slots. Storing resumes in the cycle after the flag clears.
- R8: A status read that returns 1 arms a clear latch. A later write with `reg_addr`=1 and bit 0 = 0 then clears the flag on the next edge.
- R9: With the latch unarmed, a write of 0 to bit 0 leaves the flag at 1. A write of 1 to bit 0 never changes the flag.
- R10: While `rx_en`=0, character strobes are ignored and the overrun flag keeps its value.
- R11: The clearing write consumes the arming. After a later overrun, a write of 0 without a new status read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; gates the intake of characters |
| char_valid | input | 1 | One-cycle strobe: a character has completed |
| char_data | input | 8 | Completed character |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = data register, 1 = status register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of `reg_rd`; 0 when not reading |
| fill_count | output | 5 | Number of characters held |
| rx_blocked | output | 1 | High while the overrun stall is in force |

## Verification
The bench fills the buffer to every level from 0 to 16 and drains it each time. A pointer or count wrap error would show up as a corrupted order, a wrong count or a non-zero value from an empty pop.

Around the full condition it checks three things:
- The stored characters survive an overrun, and the discarded character never reappears. A design that overwrote the newest slot would fail this.
- A design that kept storing after slots were freed would be caught by pops made during the stall.
- A design that judged fullness before the pop would wrongly flag an overrun on a push and pop in the same cycle.

For the clear sequence, the bench checks the flag through `rx_blocked` rather than through status reads, so the checks do not arm the latch themselves. It tries an unarmed write of 0, a write of 1, and the reuse of a stale arming. A design that cleared on any write of 0, or that kept the latch armed after clearing, would release the stall early.

// File: rtl/rxbuf_pkg.sv
// Package: rxbuf_pkg
// Shared constants and the register address encoding for the receive
// buffer unit. Assumes a two-entry register map selected by one address bit.
package rxbuf_pkg;
    localparam int STAT_W  = 16;  // register bus data width
    localparam int OVR_BIT = 0;   // overrun flag position in the status word

    typedef enum logic {
        RX_ADDR_DATA = 1'b0,
        RX_ADDR_STAT = 1'b1
    } rx_addr_e;
endpackage

// File: rtl/rxbuf_fifo.sv
// Module: rxbuf_fifo
// Circular character store with an occupancy count. The head entry is
// presented combinationally. Assumes DEPTH is a power of two and that the
// caller never pushes into a full store unless it pops in the same cycle.
module rxbuf_fifo #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    // Store incoming characters; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Present head entry and status flags.
    always_comb begin
        head  = mem[rd_ptr];
        count = cnt_q;
        full  = (cnt_q == CNT_W'(DEPTH));
        empty = (cnt_q == '0);
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R5
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rxbuf_ovr_flag.sv
// Module: rxbuf_ovr_flag
// Overrun flag with a read-then-write-zero clear. A status read that sees
// the flag at 1 arms a latch; a later write of 0 clears both the flag and
// the latch. Assumes set_evt is only raised while the flag is clear.
module rxbuf_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    input  logic clr_wr0,
    output logic ovr,
    output logic armed
);
    logic ovr_q, arm_q;

    // Update the flag and the arming latch; setting wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            arm_q <= 1'b0;
        end else if (set_evt) begin
            ovr_q <= 1'b1;
        end else if (clr_wr0 && arm_q) begin
            ovr_q <= 1'b0;
            arm_q <= 1'b0;
        end else if (stat_rd && ovr_q) begin
            arm_q <= 1'b1;
        end
    end

    // Drive outputs from state.
    always_comb begin
        ovr   = ovr_q;
        armed = arm_q;
    end

    // R8
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_q) |-> $past(clr_wr0 && arm_q));

    // R11
    arm_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> ovr_q);

    // R9
    unarmed_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !arm_q) |=> ovr_q);
endmodule

// File: rtl/rxbuf_bus_decode.sv
// Module: rxbuf_bus_decode
// Decodes register strobes into pop, status-read and clear-write events and
// builds the read data word. Assumes single-cycle reads with data returned
// in the strobe cycle.
module rxbuf_bus_decode
    import rxbuf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic              wbit0,
    input  logic [WIDTH-1:0]  head,
    input  logic              empty,
    input  logic              ovr,
    output logic              pop,
    output logic              stat_rd,
    output logic              clr_wr0,
    output logic [STAT_W-1:0] rdata
);
    logic sel_data, sel_stat;

    // Decode address and strobe events.
    always_comb begin
        sel_data = (reg_addr == RX_ADDR_DATA);
        sel_stat = (reg_addr == RX_ADDR_STAT);
        pop      = reg_rd && sel_data && !empty;
        stat_rd  = reg_rd && sel_stat;
        clr_wr0  = reg_wr && sel_stat && !wbit0;
    end

    // Build read data; reserved and idle bits read as zero.
    always_comb begin
        rdata = '0;
        if (reg_rd && sel_data && !empty) rdata[WIDTH-1:0] = head;
        if (reg_rd && sel_stat)           rdata[OVR_BIT]   = ovr;
    end
endmodule

// File: rtl/rxbuf_unit.sv
// Module: rxbuf_unit
// Receive-side character buffer with overrun detection and a reception
// stall. Assumes char_valid is a one-cycle strobe per completed character
// and that the register bus presents at most one access per cycle.
module rxbuf_unit
    import rxbuf_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              char_valid,
    input  logic [WIDTH-1:0]  char_data,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  fill_count,
    output logic              rx_blocked
);
    logic [WIDTH-1:0] head;
    logic             full, empty, pop, stat_rd, clr_wr0;
    logic             ovr, armed, rx_take, room, push, set_evt;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[STAT_W-1:1] ^ armed;

    rxbuf_bus_decode #(.WIDTH(WIDTH)) u_dec (
        .reg_rd  (reg_rd),
        .reg_wr  (reg_wr),
        .reg_addr(reg_addr),
        .wbit0   (reg_wdata[OVR_BIT]),
        .head    (head),
        .empty   (empty),
        .ovr     (ovr),
        .pop     (pop),
        .stat_rd (stat_rd),
        .clr_wr0 (clr_wr0),
        .rdata   (reg_rdata)
    );

    // Decide whether a completed character is stored or causes an overrun.
    always_comb begin
        rx_take = char_valid && rx_en && !ovr;
        room    = !full || pop;
        push    = rx_take && room;
        set_evt = rx_take && !room;
    end

    rxbuf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .pop  (pop),
        .wdata(char_data),
        .head (head),
        .count(fill_count),
        .full (full),
        .empty(empty)
    );

    rxbuf_ovr_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(set_evt),
        .stat_rd(stat_rd),
        .clr_wr0(clr_wr0),
        .ovr    (ovr),
        .armed  (armed)
    );

    // Expose the stall condition.
    assign rx_blocked = ovr;

    // R5
    ovr_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full && char_valid && rx_en && !pop));

    // R7
    stall_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> (fill_count <= $past(fill_count)));

    // R10
    rx_off_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !$rose(ovr));

    // R10
    rx_off_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (fill_count <= $past(fill_count)));
endmodule

// File: tb/rxbuf_unit_tb.sv
// Bench: rxbuf_unit_tb
// Fill/drain sweeps at every level plus targeted overrun and clear sequences.
module rxbuf_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b1;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [4:0]  fill_count;
    logic        rx_blocked;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rxbuf_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .char_valid(char_valid), .char_data(char_data),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fill_count(fill_count), .rx_blocked(rx_blocked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push_char(input logic [7:0] d);
        @(negedge clk); char_valid = 1'b1; char_data = d;
        @(posedge clk); #1; char_valid = 1'b0;
    endtask

    task automatic read_reg(input logic a, output logic [15:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1; reg_rd = 1'b0;
    endtask

    task automatic write_reg(input logic a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1; reg_wr = 1'b0;
    endtask

    task automatic fill_full(input logic [7:0] base);
        for (int i = 0; i < 16; i++) push_char(base + 8'(i));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        do_reset();
        // R1 reset state
        chk("R1 count", fill_count, 0);
        chk("R1 blocked", rx_blocked, 0);
        read_reg(1'b1, v);
        chk("R1 status", v, 0);

        // R2/R3 sweep every fill level
        for (int n = 0; n <= 16; n++) begin
            for (int i = 0; i < n; i++) push_char(8'((n * 16 + i * 7) & 255));
            chk("R2 count after fill", fill_count, n);
            for (int i = 0; i < n; i++) begin
                read_reg(1'b0, v);
                chk("R3 order", v, (n * 16 + i * 7) & 255);
                chk("R3 count after pop", fill_count, n - i - 1);
            end
            read_reg(1'b0, v);
            chk("R3 empty pop data", v, 0);
            chk("R3 empty pop count", fill_count, 0);
        end

        // R4 reserved bits ignore writes
        write_reg(1'b1, 16'hFFFE);
        chk("R4 blocked after reserved write", rx_blocked, 0);
        read_reg(1'b1, v);
        chk("R4 status reserved", v, 0);

        // R10 intake gated by rx_en
        rx_en = 1'b0;
        for (int i = 0; i < 3; i++) push_char(8'h30 + 8'(i));
        chk("R10 ignored chars", fill_count, 0);
        rx_en = 1'b1;

        // R5 overrun keeps stored characters
        fill_full(8'hA0);
        chk("R5 full count", fill_count, 16);
        push_char(8'h55);
        chk("R5 flag set", rx_blocked, 1);
        chk("R5 count kept", fill_count, 16);
        read_reg(1'b1, v);
        chk("R4 status flag bit", v, 16'h0001);

        // R7 stall despite freed slots
        read_reg(1'b0, v); chk("R7 pop during stall 0", v, 8'hA0);
        read_reg(1'b0, v); chk("R7 pop during stall 1", v, 8'hA1);
        push_char(8'h66); push_char(8'h67);
        chk("R7 no store while set", fill_count, 14);

        // R10 rx_en low keeps flag
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 flag kept", rx_blocked, 1);
        rx_en = 1'b1;

        // R9 write 1 has no effect
        write_reg(1'b1, 16'hFFFF);
        chk("R9 write1 no effect", rx_blocked, 1);

        // R8 armed write 0 clears
        write_reg(1'b1, 16'h0000);
        chk("R8 cleared", rx_blocked, 0);
        push_char(8'h77);
        chk("R7 resume store", fill_count, 15);
        for (int i = 2; i < 16; i++) begin
            read_reg(1'b0, v);
            chk("R5 stored intact", v, 8'hA0 + i);
        end
        read_reg(1'b0, v);
        chk("R7 resumed char", v, 8'h77);
        chk("R3 drained", fill_count, 0);

        // R9 unarmed write 0 keeps flag
        fill_full(8'h10);
        push_char(8'h99);
        chk("R5 second overrun", rx_blocked, 1);
        write_reg(1'b1, 16'h0000);
        chk("R9 unarmed write0", rx_blocked, 1);
        read_reg(1'b1, v);
        write_reg(1'b1, 16'h0000);
        chk("R8 clear after read", rx_blocked, 0);

        // R11 arming consumed by clearing write
        push_char(8'h42);
        chk("R11 overrun again", rx_blocked, 1);
        write_reg(1'b1, 16'h0000);
        chk("R11 stale arm not reused", rx_blocked, 1);
        read_reg(1'b1, v);
        write_reg(1'b1, 16'h0000);
        chk("R11 fresh arm clears", rx_blocked, 0);

        // R6 push and pop in same cycle when full
        do_reset();
        fill_full(8'hC0);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 1'b0; char_valid = 1'b1; char_data = 8'hEE;
        #1 v = reg_rdata;
        @(posedge clk); #1; reg_rd = 1'b0; char_valid = 1'b0;
        chk("R6 popped head", v, 8'hC0);
        chk("R6 no flag", rx_blocked, 0);
        chk("R6 count", fill_count, 16);
        for (int i = 1; i < 16; i++) begin
            read_reg(1'b0, v);
            chk("R6 order", v, 8'hC0 + i);
        end
        read_reg(1'b0, v);
        chk("R6 tail char", v, 8'hEE);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule